// File: doc/BRIEF.md
# Output Enable and Power-Down Controller

This block sits beside the clock divider of a two-output programmable oscillator. It takes two control pins and four configuration bits, and turns them into a tristate enable for each clock output, a source select for the first output and a power-down request for the master oscillator. Control pin 0 has several uses. Depending on the configuration it is an output disable, a source selector, or a power-down input. Control pin 1 is either an output disable for the second output or a power-down input. The power-down requests from the two pins are ORed.

All requests are sequenced in the master clock domain. An output is only switched to high impedance while its own clock is low, so no short high pulse reaches the pin. Before power-down, both outputs are first taken off. Only then is the oscillator stop requested, and register programming is blocked while it is stopped. After reset or wake-up, both outputs stay off for a programmable stabilization time.

Top module: `outgate_pwr_ctrl`

## Requirements
- R1: Each control pin passes through SYNC_STAGES flip-flops before it is decoded. A pin change cannot alter any output at the first clock edge after the change.
- R2: With mode_pdn0=1, control pin 0 high requests power-down whatever mode_en0 is. While awake, output 0 is enabled, and out0_src_sel equals mode_sel0.
- R3: With mode_pdn0=0 and mode_en0=1, control pin 0 high disables output 0 and control pin 0 low enables it. out0_src_sel equals mode_sel0 (0 = master clock, 1 = prescaled clock).
- R4: With mode_pdn0=0, mode_en0=0 and mode_sel0=1, control pin 0 drives out0_src_sel (0 = master clock, 1 = prescaled clock), and output 0 stays enabled.
- R5: With mode_en0, mode_sel0 and mode_pdn0 all 0, output 0 is never enabled, and control pin 0 high requests power-down.
- R6: With mode_pdn1=0, control pin 1 high disables output 1 and leaves output 0 unchanged. With mode_pdn1=1, control pin 1 high requests power-down.
- R7: The device powers down when either pin's qualified power-down condition is true. A pin whose mode gives it no power-down role does not power the device down.
- R8: An output enable falls only at a clock edge where that output's raw clock is sampled low. While the raw clock stays high, the enable stays high.
- R9: osc_pd_req is never high while either output enable is high.
- R10: After reset, and after osc_pd_req falls, both enables stay low for at least STAB_CYCLES cycles. In a mode where output 0 is wanted, out0_oe rises exactly SYNC_STAGES+STAB_CYCLES+2 cycles after a power-down pin is released.
- R11: prog_block is high exactly while the oscillator is powered down, that is, while osc_pd_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl0_pin | input | 1 | Multi-function control pin 0 (asynchronous) |
| ctrl1_pin | input | 1 | Control pin 1 (asynchronous) |
| mode_en0 | input | 1 | Pin 0 acts as output disable |
| mode_sel0 | input | 1 | Output 0 source, or pin 0 as selector |
| mode_pdn0 | input | 1 | Pin 0 acts as power-down |
| mode_pdn1 | input | 1 | Pin 1 acts as power-down |
| out0_clk_raw | input | 1 | Ungated clock of output 0 |
| out1_clk_raw | input | 1 | Ungated clock of output 1 |
| out0_oe | output | 1 | Tristate enable of output 0 (1 = driving) |
| out1_oe | output | 1 | Tristate enable of output 1 (1 = driving) |
| out0_src_sel | output | 1 | Output 0 source: 0 master, 1 prescaled |
| osc_pd_req | output | 1 | Oscillator power-down request |
| prog_block | output | 1 | Register programming inhibited |

## Verification
The bench builds the block with STAB_CYCLES=16 and SYNC_STAGES=2. This keeps each wake-up short, so every mode can be taken through power-down and back several times, and the exact wake-up latency can be counted cycle by cycle. Both raw output clocks run at a few master cycles per phase. One of them can be held high, which shows that a disable waits for the low phase and that power-down waits for the drain.

// File: rtl/ogp_pkg.sv
package ogp_pkg;

  typedef enum logic [1:0] {
    PS_STAB  = 2'd0,
    PS_RUN   = 2'd1,
    PS_DRAIN = 2'd2,
    PS_DOWN  = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic want0;
    logic want1;
    logic src0;
    logic pd;
  } pin_dec_t;

endpackage

// File: rtl/ogp_sync.sv
module ogp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ogp_decode.sv
module ogp_decode
  import ogp_pkg::*;
(
  input  logic     pin0,
  input  logic     pin1,
  input  logic     en0,
  input  logic     sel0,
  input  logic     pdn0,
  input  logic     pdn1,
  output pin_dec_t dec
);
  logic pd0, pd1;

  always_comb begin
    dec.want0 = 1'b1;
    dec.src0  = sel0;
    pd0       = 1'b0;
    if (pdn0) begin
      // pin 0 is a power-down input; output 0 runs while awake
      pd0 = pin0;
    end else if (en0) begin
      // pin 0 is an active-high output disable
      dec.want0 = ~pin0;
    end else if (sel0) begin
      // pin 0 steers the source mux
      dec.src0 = pin0;
    end else begin
      // output 0 unused: pin 0 shuts the device down
      dec.want0 = 1'b0;
      dec.src0  = 1'b0;
      pd0       = pin0;
    end
    pd1       = pdn1 & pin1;
    dec.want1 = pdn1 | ~pin1;
    dec.pd    = pd0 | pd1;
  end
endmodule

// File: rtl/ogp_gate.sv
module ogp_gate (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic clk_raw,
  output logic oe
);
  always_ff @(posedge clk) begin
    if (rst)                    oe <= 1'b0;
    else if (want)              oe <= 1'b1;
    else if (oe && !clk_raw)    oe <= 1'b0;
  end
endmodule

// File: rtl/ogp_seq.sv
module ogp_seq
  import ogp_pkg::*;
#(
  parameter int STAB_CYCLES = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  input  logic outs_off,
  output logic allow,
  output logic osc_pd,
  output logic prog_blk
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STAB_CYCLES - 1);

  pwr_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PS_STAB: begin
        if (pd_req)                st_d = PS_DRAIN;
        else if (cnt_q == CNT_LAST) st_d = PS_RUN;
        else                       cnt_d = cnt_q + 1'b1;
      end
      PS_RUN:   if (pd_req)   st_d = PS_DRAIN;
      PS_DRAIN: if (outs_off) st_d = PS_DOWN;
      PS_DOWN: begin
        if (!pd_req) begin
          st_d  = PS_STAB;
          cnt_d = '0;
        end
      end
      default: st_d = PS_STAB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PS_STAB;
      cnt_q    <= '0;
      osc_pd   <= 1'b0;
      prog_blk <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      osc_pd   <= (st_d == PS_DOWN);
      prog_blk <= (st_d == PS_DOWN);
    end
  end

  assign allow = (st_q == PS_RUN);
endmodule

// File: rtl/outgate_pwr_ctrl.sv
module outgate_pwr_ctrl
  import ogp_pkg::*;
#(
  parameter int STAB_CYCLES = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl0_pin,
  input  logic ctrl1_pin,
  input  logic mode_en0,
  input  logic mode_sel0,
  input  logic mode_pdn0,
  input  logic mode_pdn1,
  input  logic out0_clk_raw,
  input  logic out1_clk_raw,
  output logic out0_oe,
  output logic out1_oe,
  output logic out0_src_sel,
  output logic osc_pd_req,
  output logic prog_block
);
  localparam int NPIN = 2;
  localparam int NOUT = 2;

  logic [NPIN-1:0] pin_raw, pin_s;
  logic [NOUT-1:0] clk_raw, want, oe;
  pin_dec_t        dec;
  logic            allow;

  assign pin_raw = {ctrl1_pin, ctrl0_pin};
  assign clk_raw = {out1_clk_raw, out0_clk_raw};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    ogp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_raw[i]),
      .q   (pin_s[i])
    );
  end

  ogp_decode u_dec (
    .pin0 (pin_s[0]),
    .pin1 (pin_s[1]),
    .en0  (mode_en0),
    .sel0 (mode_sel0),
    .pdn0 (mode_pdn0),
    .pdn1 (mode_pdn1),
    .dec  (dec)
  );

  ogp_seq #(.STAB_CYCLES(STAB_CYCLES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .pd_req   (dec.pd),
    .outs_off (~|oe),
    .allow    (allow),
    .osc_pd   (osc_pd_req),
    .prog_blk (prog_block)
  );

  assign want = {allow & dec.want1, allow & dec.want0};

  for (genvar j = 0; j < NOUT; j++) begin : g_gate
    ogp_gate u_gate (
      .clk     (clk),
      .rst     (rst),
      .want    (want[j]),
      .clk_raw (clk_raw[j]),
      .oe      (oe[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out0_src_sel <= 1'b0;
    else     out0_src_sel <= dec.src0;
  end

  assign out0_oe = oe[0];
  assign out1_oe = oe[1];
endmodule

// File: rtl/ogp_checker.sv
module ogp_checker #(
  parameter int STAB_CYCLES = 8000
) (
  input logic clk,
  input logic rst,
  input logic mode_en0,
  input logic mode_sel0,
  input logic mode_pdn0,
  input logic out0_clk_raw,
  input logic out1_clk_raw,
  input logic out0_oe,
  input logic out1_oe,
  input logic osc_pd_req,
  input logic prog_block
);
  localparam int QW = $clog2(STAB_CYCLES + 2);
  localparam logic [QW-1:0] QMAX = QW'(STAB_CYCLES);

  // cycles since reset or since the oscillator was last stopped (saturating)
  logic [QW-1:0] quiet;
  always_ff @(posedge clk) begin
    if (rst || osc_pd_req) quiet <= '0;
    else if (quiet != QMAX) quiet <= quiet + 1'b1;
  end

  assert_smart_off0_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(out0_oe) |-> !$past(out0_clk_raw));
  assert_smart_off1_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(out1_oe) |-> !$past(out1_clk_raw));
  assert_off_before_pd_R9: assert property (@(posedge clk) disable iff (rst)
    osc_pd_req |-> (!out0_oe && !out1_oe));
  assert_stab_wait0_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out0_oe) |-> (quiet >= QMAX));
  assert_stab_wait1_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out1_oe) |-> (quiet >= QMAX));
  assert_unused_out0_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out0_oe) |-> $past(mode_en0 || mode_sel0 || mode_pdn0));
  assert_prog_blk_R11: assert property (@(posedge clk) disable iff (rst)
    prog_block == osc_pd_req);
endmodule

bind outgate_pwr_ctrl ogp_checker #(.STAB_CYCLES(STAB_CYCLES)) u_ogp_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_en0     (mode_en0),
  .mode_sel0    (mode_sel0),
  .mode_pdn0    (mode_pdn0),
  .out0_clk_raw (out0_clk_raw),
  .out1_clk_raw (out1_clk_raw),
  .out0_oe      (out0_oe),
  .out1_oe      (out1_oe),
  .osc_pd_req   (osc_pd_req),
  .prog_block   (prog_block)
);

// File: tb/tb_outgate_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_outgate_pwr_ctrl;
  localparam int STAB = 16;
  localparam int SYNC = 2;
  localparam int SETTLE = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl0 = 1'b0, ctrl1 = 1'b0;
  logic en0 = 1'b1, sel0 = 1'b1, pdn0 = 1'b0, pdn1 = 1'b0;
  logic raw0 = 1'b0, raw1 = 1'b0;
  logic hold1 = 1'b0;
  logic oe0, oe1, src0, osc_pd, prog;

  int total = 0;
  int bad = 0;
  int seq_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  outgate_pwr_ctrl #(.STAB_CYCLES(STAB), .SYNC_STAGES(SYNC)) dut (
    .clk (clk), .rst (rst),
    .ctrl0_pin (ctrl0), .ctrl1_pin (ctrl1),
    .mode_en0 (en0), .mode_sel0 (sel0), .mode_pdn0 (pdn0), .mode_pdn1 (pdn1),
    .out0_clk_raw (raw0), .out1_clk_raw (raw1),
    .out0_oe (oe0), .out1_oe (oe1), .out0_src_sel (src0),
    .osc_pd_req (osc_pd), .prog_block (prog)
  );

  // raw output clocks: output 0 toggles every 2 cycles, output 1 every 3 (or held high)
  initial begin
    int c0 = 0;
    int c1 = 0;
    forever begin
      @(negedge clk);
      c0++;
      if (c0 == 2) begin c0 = 0; raw0 = ~raw0; end
      if (hold1) raw1 = 1'b1;
      else begin
        c1++;
        if (c1 == 3) begin c1 = 0; raw1 = ~raw1; end
      end
    end
  end

  // R9 ordering monitor
  always @(negedge clk) if (!rst && osc_pd && (oe0 || oe1)) seq_bad++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic e, input logic s, input logic p0, input logic p1);
    en0 = e; sel0 = s; pdn0 = p0; pdn1 = p1;
  endtask

  task automatic back_to_default();
    ctrl0 = 1'b0; ctrl1 = 1'b0; hold1 = 1'b0;
    set_mode(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(STAB + SETTLE + 4);
  endtask

  task automatic t_reset();
    cyc(2);
    check("R10 reset oe0 off", int'(oe0), 0);
    check("R10 reset oe1 off", int'(oe1), 0);
    check("R11 reset osc_pd", int'(osc_pd), 0);
    check("R11 reset prog", int'(prog), 0);
    cyc(STAB + SETTLE);
    check("R10 oe0 after stab", int'(oe0), 1);
    check("R10 oe1 after stab", int'(oe1), 1);
    check("R3 default src", int'(src0), 1);
  endtask

  task automatic t_sync_disable();
    ctrl0 = 1'b1;
    cyc(1);
    check("R1 no change after one edge", int'(oe0), 1);
    cyc(SETTLE);
    check("R3 pin0 high disables out0", int'(oe0), 0);
    check("R3 out1 untouched", int'(oe1), 1);
    check("R7 no pd in disable mode", int'(osc_pd), 0);
    ctrl0 = 1'b0;
    cyc(SETTLE);
    check("R3 pin0 low enables out0", int'(oe0), 1);
    sel0 = 1'b0;
    cyc(SETTLE);
    check("R3 src follows sel0=0", int'(src0), 0);
    sel0 = 1'b1;
    cyc(SETTLE);
    check("R3 src follows sel0=1", int'(src0), 1);
  endtask

  task automatic t_mux_mode();
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    ctrl0 = 1'b0;
    cyc(SETTLE);
    check("R4 pin0=0 master src", int'(src0), 0);
    check("R4 out0 enabled", int'(oe0), 1);
    ctrl0 = 1'b1;
    cyc(SETTLE);
    check("R4 pin0=1 prescaled src", int'(src0), 1);
    check("R4 out0 still enabled", int'(oe0), 1);
    check("R7 no pd in mux mode", int'(osc_pd), 0);
    back_to_default();
  endtask

  task automatic t_unused_out0();
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(SETTLE);
    check("R5 out0 never enabled", int'(oe0), 0);
    check("R5 out1 still runs", int'(oe1), 1);
    ctrl0 = 1'b1;
    cyc(SETTLE);
    check("R5 pin0 powers down", int'(osc_pd), 1);
    check("R11 prog blocked", int'(prog), 1);
    check("R9 out1 off in pd", int'(oe1), 0);
    ctrl0 = 1'b0;
    cyc(STAB + SETTLE);
    check("R5 wake osc", int'(osc_pd), 0);
    check("R11 prog released", int'(prog), 0);
    check("R5 out0 stays off after wake", int'(oe0), 0);
    check("R10 out1 back after wake", int'(oe1), 1);
    back_to_default();
  endtask

  task automatic t_pdn0_mode();
    set_mode(1'b1, 1'b0, 1'b1, 1'b0);
    cyc(SETTLE);
    check("R2 out0 enabled while awake", int'(oe0), 1);
    check("R2 src from sel0", int'(src0), 0);
    ctrl0 = 1'b1;
    cyc(SETTLE);
    check("R2 pin0 powers down despite en0", int'(osc_pd), 1);
    check("R9 out0 off in pd", int'(oe0), 0);
    ctrl0 = 1'b0;
    cyc(STAB + SETTLE);
    check("R2 awake again", int'(osc_pd), 0);
    check("R2 out0 back", int'(oe0), 1);
    back_to_default();
  endtask

  task automatic t_pin1_smart();
    hold1 = 1'b1;
    cyc(2);
    ctrl1 = 1'b1;
    cyc(SETTLE);
    check("R8 oe1 held while clock high", int'(oe1), 1);
    hold1 = 1'b0;
    cyc(SETTLE);
    check("R6 pin1 disables out1", int'(oe1), 0);
    check("R6 out0 untouched", int'(oe0), 1);
    check("R7 pin1 no pd when pdn1=0", int'(osc_pd), 0);
    ctrl1 = 1'b0;
    cyc(SETTLE);
    check("R6 out1 re-enabled", int'(oe1), 1);
    // power-down must wait for the drain while out1 clock is held high
    pdn1 = 1'b1;
    hold1 = 1'b1;
    cyc(2);
    ctrl1 = 1'b1;
    cyc(SETTLE);
    check("R9 pd waits for drain", int'(osc_pd), 0);
    hold1 = 1'b0;
    cyc(SETTLE);
    check("R6 pin1 powers down", int'(osc_pd), 1);
    back_to_default();
  endtask

  task automatic t_or_and_wake();
    int n;
    set_mode(1'b1, 1'b1, 1'b1, 1'b1);
    cyc(SETTLE);
    ctrl1 = 1'b1;
    cyc(SETTLE);
    check("R7 pin1 alone powers down", int'(osc_pd), 1);
    ctrl1 = 1'b0;
    ctrl0 = 1'b1;
    cyc(SETTLE);
    check("R7 pin0 alone keeps pd", int'(osc_pd), 1);
    ctrl0 = 1'b0;
    cyc(STAB + SETTLE);
    check("R7 both low awake", int'(osc_pd), 0);
    // exact wake latency
    ctrl1 = 1'b1;
    cyc(SETTLE);
    check("R11 prog in pd", int'(prog), 1);
    ctrl1 = 1'b0;
    n = 0;
    while (!oe0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    check("R10 wake latency", n, SYNC + STAB + 2);
    check("R9 ordering monitor", seq_bad, 0);
    back_to_default();
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    t_reset();
    t_sync_disable();
    t_mux_mode();
    t_unused_out0();
    t_pdn0_mode();
    t_pin1_smart();
    t_or_and_wake();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule